// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block derives the two clocks an audio serial port needs from a single source clock. One is a master clock for external converters; the other is the bit clock that paces the serial data. Both rates come from divider fields held in one 32-bit control register. Software writes that register through a simple write strobe and can read it back.

The two dividers follow different rules. The master clock divides the source by twice its field value. A field value of zero sends the source clock straight through. The bit clock divides the source by twice the field value plus one, so a zero field gives half the source rate. The master clock runs only while its enable input is high. The bit clock runs only while the port is in master mode. When the shared serial peripheral is in plain SPI mode, the register ignores writes and both outputs stay low.

Each divider is a small state machine with three states. DIV_OFF holds the output low with the counter cleared. DIV_RUN counts source cycles and toggles the output at the end of each half period. DIV_PASS, used only by the master divider, passes the source clock through. The transitions are: OFF to RUN (or to PASS for a zero master field) when the divider is allowed to run; RUN and PASS back to OFF when it is not; RUN to PASS when the output ends a high half and the field is zero; and PASS to RUN as soon as the field becomes nonzero. A new field value is loaded only when the output toggles, so no half period is ever cut short.

Top module: `aud_serial_clkgen`

## Requirements
- R1: After reset the register reads 0x0000_0000 and both clock outputs are low.
- R2: The bit-clock field is register bits [16:8] (9 bits) and the master-clock field is bits [5:0] (6 bits). Bits [31:17] and [7:6] read as zero and ignore writes, so a write of W reads back as W & 0x0001_FF3F.
- R3: In master mode the bit clock has a period of 2×(B+1) source cycles, high for B+1 cycles and low for B+1 cycles, for every B from 0 to 511.
- R4: While master mode is low, the bit clock stays low.
- R5: With the enable high and a master field M from 1 to 63, the master clock has a period of 2×M source cycles, high for M cycles and low for M cycles.
- R6: With the enable high and a master field of 0, the master clock equals the source clock: high while the source is high, low while it is low.
- R7: While the master-clock enable is low, the master clock stays low.
- R8: While SPI mode is high, writes leave the register unchanged and both clock outputs are low.
- R9: After a divider field is rewritten, every high or low phase lasts either the old half period or the new one, never a shortened length; once the new value has taken effect, only the new length occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read-back value |
| spi_mode | input | 1 | Shared peripheral is in plain SPI mode |
| mclk_en | input | 1 | Master clock enable |
| master_mode | input | 1 | Port is the clock master |
| mclk_o | output | 1 | Master clock output |
| bclk_o | output | 1 | Bit clock output |

## Verification
Assertions check four things on every cycle. The counter never reaches the loaded half period. The output toggles only at the end of a counted half period. A stopped divider drops to the off state with its output low. The register takes a legal write and stays frozen in SPI mode. Only the bench's scenarios can show the things that depend on whole periods or on the source clock waveform: the period and duty measured for every master setting and for the bit-clock settings that were swept (including the extremes), the pass-through of the source clock, reserved-bit masking, and the phase lengths seen across a reload in the middle of a period.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;
    localparam int REG_W   = 32;
    localparam int BDIV_W  = 9;
    localparam int BDIV_LO = 8;
    localparam int MDIV_W  = 6;
    localparam int MDIV_LO = 0;

    typedef enum logic [1:0] {
        DIV_OFF  = 2'd0,
        DIV_RUN  = 2'd1,
        DIV_PASS = 2'd2
    } div_state_e;
endpackage

// File: rtl/aud_clk_cfg_reg.sv
module aud_clk_cfg_reg
    import aud_clk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              lock,
    output logic [BDIV_W-1:0] bdiv,
    output logic [MDIV_W-1:0] mdiv,
    output logic [REG_W-1:0]  rd_data
);
    localparam int BDIV_HI = BDIV_LO + BDIV_W - 1;
    localparam int MDIV_HI = MDIV_LO + MDIV_W - 1;

    logic [BDIV_W-1:0] bdiv_q;
    logic [MDIV_W-1:0] mdiv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bdiv_q <= '0;
            mdiv_q <= '0;
        end else if (wr_en && !lock) begin
            bdiv_q <= wr_data[BDIV_HI:BDIV_LO];
            mdiv_q <= wr_data[MDIV_HI:MDIV_LO];
        end
    end

    always_comb begin
        rd_data = '0;
        rd_data[BDIV_HI:BDIV_LO] = bdiv_q;
        rd_data[MDIV_HI:MDIV_LO] = mdiv_q;
    end

    assign bdiv = bdiv_q;
    assign mdiv = mdiv_q;

    // R2
    field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !lock) |=> (rd_data[BDIV_HI:BDIV_LO] == $past(wr_data[BDIV_HI:BDIV_LO]))
                          && (rd_data[MDIV_HI:MDIV_LO] == $past(wr_data[MDIV_HI:MDIV_LO])));

    // R8
    spi_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(rd_data));
endmodule

// File: rtl/aud_clk_div.sv
module aud_clk_div
    import aud_clk_pkg::*;
#(
    parameter int W           = 6,
    parameter bit ZERO_BYPASS = 1'b0
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] div_i,
    output logic         out_o
);
    localparam int HW = W + 1;

    div_state_e    state_q, state_d;
    logic [HW-1:0] cnt_q;
    logic [HW-1:0] half_q;
    logic          out_q;
    logic [HW-1:0] half_new;
    logic [HW-1:0] half_safe;
    logic          want_pass;
    logic          boundary;

    generate
        if (ZERO_BYPASS) begin : g_bypass_law
            assign half_new  = {1'b0, div_i};
            assign want_pass = (div_i == '0);
        end else begin : g_plus_one_law
            assign half_new  = {1'b0, div_i} + HW'(1);
            assign want_pass = 1'b0;
        end
    endgenerate

    assign half_safe = (half_new == '0) ? HW'(1) : half_new;
    assign boundary  = (cnt_q == half_q - HW'(1));

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_OFF: begin
                if (run_i) state_d = want_pass ? DIV_PASS : DIV_RUN;
            end
            DIV_RUN: begin
                if (!run_i)                             state_d = DIV_OFF;
                else if (boundary && out_q && want_pass) state_d = DIV_PASS;
            end
            DIV_PASS: begin
                if (!run_i)          state_d = DIV_OFF;
                else if (!want_pass) state_d = DIV_RUN;
            end
            default: state_d = DIV_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIV_OFF;
        else        state_q <= state_d;
    end

    // counter and output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            half_q <= HW'(1);
            out_q  <= 1'b0;
        end else begin
            unique case (state_q)
                DIV_OFF: begin
                    cnt_q  <= '0;
                    out_q  <= 1'b0;
                    half_q <= half_safe;
                end
                DIV_RUN: begin
                    if (!run_i) begin
                        cnt_q <= '0;
                        out_q <= 1'b0;
                    end else if (boundary) begin
                        cnt_q  <= '0;
                        out_q  <= ~out_q;
                        half_q <= half_safe;
                    end else begin
                        cnt_q <= cnt_q + HW'(1);
                    end
                end
                DIV_PASS: begin
                    cnt_q  <= '0;
                    out_q  <= run_i;
                    half_q <= half_safe;
                end
                default: begin
                    cnt_q <= '0;
                    out_q <= 1'b0;
                end
            endcase
        end
    end

    // output process
    always_comb begin
        unique case (state_q)
            DIV_PASS: out_o = clk;
            DIV_RUN:  out_o = out_q;
            default:  out_o = 1'b0;
        endcase
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DIV_RUN) |-> (cnt_q < half_q));

    // R3
    toggle_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == DIV_RUN) && ($past(state_q) == DIV_RUN) && (out_q != $past(out_q)))
        |-> ($past(cnt_q) == $past(half_q) - HW'(1)));

    // R4
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> ((state_q == DIV_OFF) && !out_q));
endmodule

// File: rtl/aud_serial_clkgen.sv
module aud_serial_clkgen
    import aud_clk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        spi_mode,
    input  logic        mclk_en,
    input  logic        master_mode,
    output logic        mclk_o,
    output logic        bclk_o
);
    logic [BDIV_W-1:0] bdiv;
    logic [MDIV_W-1:0] mdiv;
    logic              m_run;
    logic              b_run;

    aud_clk_cfg_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .lock    (spi_mode),
        .bdiv    (bdiv),
        .mdiv    (mdiv),
        .rd_data (cfg_rdata)
    );

    assign m_run = mclk_en && !spi_mode;
    assign b_run = master_mode && !spi_mode;

    aud_clk_div #(.W(MDIV_W), .ZERO_BYPASS(1'b1)) u_mdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (m_run),
        .div_i (mdiv),
        .out_o (mclk_o)
    );

    aud_clk_div #(.W(BDIV_W), .ZERO_BYPASS(1'b0)) u_bdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (b_run),
        .div_i (bdiv),
        .out_o (bclk_o)
    );

    // R7
    mclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !m_run |=> !u_mdiv.out_q);
endmodule

// File: tb/aud_serial_clkgen_tb.sv
`timescale 1ns/1ps
module aud_serial_clkgen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        spi_mode = 1'b0;
    logic        mclk_en = 1'b0;
    logic        master_mode = 1'b0;
    logic        mclk_o;
    logic        bclk_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    aud_serial_clkgen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .spi_mode(spi_mode), .mclk_en(mclk_en),
        .master_mode(master_mode), .mclk_o(mclk_o), .bclk_o(bclk_o)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 180000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected under 180000", cycles);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic pick(input bit sel);
        return sel ? bclk_o : mclk_o;
    endfunction

    // counts negedge samples until the selected output changes
    task automatic next_seg(input bit sel, output int n);
        logic v;
        v = pick(sel);
        n = 0;
        while (pick(sel) == v && n < 4000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure(input bit sel, output int a, output int b);
        int d;
        next_seg(sel, d);
        next_seg(sel, d);
        next_seg(sel, a);
        next_seg(sel, b);
    endtask

    task automatic stay_low(input bit sel, input int n, input string req);
        int highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pick(sel)) highs++;
            #12;
            if (pick(sel)) highs++;
        end
        chk(highs == 0, req, highs, 0);
    endtask

    initial begin
        int a, b, seg, bad, h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(cfg_rdata == 32'h0, "R1", cfg_rdata, 0);
        chk(mclk_o == 1'b0, "R1", mclk_o, 0);
        chk(bclk_o == 1'b0, "R1", bclk_o, 0);

        // R2 field layout and reserved bits
        wr_reg(32'hFFFF_FFFF);
        @(negedge clk);
        chk(cfg_rdata == 32'h0001_FF3F, "R2", cfg_rdata, 32'h0001_FF3F);
        wr_reg(32'hA5A5_A5A5);
        @(negedge clk);
        chk(cfg_rdata == (32'hA5A5_A5A5 & 32'h0001_FF3F), "R2", cfg_rdata,
            32'hA5A5_A5A5 & 32'h0001_FF3F);

        // R7 enable low holds master clock low
        stay_low(1'b0, 40, "R7");

        // R5 full sweep of nonzero master field
        mclk_en = 1'b1;
        for (int m = 1; m < 64; m++) begin
            wr_reg(32'(m));
            measure(1'b0, a, b);
            chk(a == m, "R5", a, m);
            chk(b == m, "R5", b, m);
        end

        // R6 zero master field passes the source clock
        wr_reg(32'h0);
        repeat (200) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            #1;
            if (mclk_o !== 1'b0) bad++;
            @(posedge clk);
            #1;
            if (mclk_o !== 1'b1) bad++;
        end
        chk(bad == 0, "R6", bad, 0);

        // R7 dropping the enable forces the master clock low
        mclk_en = 1'b0;
        repeat (2) @(negedge clk);
        stay_low(1'b0, 30, "R7");

        // R4 bit clock idle outside master mode
        wr_reg(32'h0000_0300);
        stay_low(1'b1, 30, "R4");

        // R3 bit clock sweep with extremes
        master_mode = 1'b1;
        for (int k = 0; k < 18; k++) begin
            int bv;
            bv = (k < 16) ? k : ((k == 16) ? 255 : 511);
            wr_reg(32'(bv) << 8);
            measure(1'b1, a, b);
            chk(a == bv + 1, "R3", a, bv + 1);
            chk(b == bv + 1, "R3", b, bv + 1);
        end

        // R4 leaving master mode stops the bit clock
        master_mode = 1'b0;
        repeat (2) @(negedge clk);
        stay_low(1'b1, 30, "R4");

        // R9 reload in the middle of a phase
        mclk_en = 1'b1;
        wr_reg(32'd5);
        measure(1'b0, a, b);
        repeat (2) @(negedge clk);
        wr_reg(32'd20);
        bad = 0;
        h = 0;
        for (int i = 0; i < 8; i++) begin
            next_seg(1'b0, seg);
            if (i > 0) begin
                if (seg != 5 && seg != 20) bad++;
                if (h && seg != 20) bad++;
                if (seg == 20) h = 1;
            end
        end
        chk(bad == 0, "R9", bad, 0);
        chk(h == 1, "R9", h, 1);

        // R8 SPI mode locks register and silences both clocks
        master_mode = 1'b1;
        wr_reg(32'h0000_0203);
        spi_mode = 1'b1;
        wr_reg(32'h0001_FF3F);
        @(negedge clk);
        chk(cfg_rdata == 32'h0000_0203, "R8", cfg_rdata, 32'h0000_0203);
        repeat (2) @(negedge clk);
        stay_low(1'b0, 30, "R8");
        stay_low(1'b1, 30, "R8");
        spi_mode = 1'b0;
        measure(1'b0, a, b);
        chk(a == 3, "R8", a, 3);

        summary();
    end
endmodule